// File: doc/BRIEF.md
# Feature-Enable Access Gate

This block keeps three privilege-level feature-enable registers (machine, hypervisor, supervisor), each reduced to two meaningful bits. Bit 1 enables floating-point instructions on cores whose floating-point operations use the integer register file. Bit 2 enables the table-jump instructions, both the plain jump and the jump-and-link form, together with the CSR that holds the jump vector table base. All other register bits read as zero.

For every decoded instruction the block combines the decoder's flags with the current privilege level, the virtualization mode and the three registers. It forms a combinational verdict with three values: PASS (no trap), ILLEGAL (illegal-instruction trap) or VIRTUAL (virtual-instruction trap). The verdict is presented as a trap request plus a trap-type bit. The pipeline's trap logic consumes the request. Machine software opens features for lower levels by setting bits, and each lower level can only narrow what the level above allows.

Top module: `fen_access_gate`

## Requirements
- R1: After reset all three registers read zero, so a gated access below machine mode traps as ILLEGAL.
- R2: A write to a register takes effect at the next rising clock edge. Read data carries the floating-point enable at bit position 1 and the table-jump enable at bit position 2. All other positions read zero.
- R3: While `fp_present_i` is 1, bit 1 of the machine register reads zero and writes to it are ignored. The hypervisor and supervisor registers then also read zero at bit 1.
- R4: The hypervisor register reads its stored bits ANDed with the machine read value. The supervisor register reads its stored bits ANDed with the hypervisor read value. Stored lower bits reappear when the upper bit is set again.
- R5: In machine mode (`priv_i` = 2'b11) no access ever traps.
- R6: Below machine mode (user = 2'b00, supervisor = 2'b01), an access whose machine bit is zero traps as ILLEGAL (`trap_o`=1, `trap_virt_o`=0). This holds even when virtualized.
- R7: With the machine bit set, `virt_i`=1 and the hypervisor bit zero, the access traps as VIRTUAL (`trap_o`=1, `trap_virt_o`=1).
- R8: In user mode, with the higher bits allowing the access and the supervisor bit zero, the access traps. The trap is ILLEGAL when `virt_i`=0 and VIRTUAL when `virt_i`=1.
- R9: A floating-point instruction (`dec_fp_i`) is gated by bit 1 only while `fp_present_i`=0. While `fp_present_i`=1 it never traps.
- R10: Both a table-jump instruction (`dec_tjump_i`) and an access to the jump vector table CSR (`dec_vtcsr_i`) are gated by bit 2 alone.
- R11: An instruction with none of the decode flags set never traps, whatever the register contents. Other compressed-instruction subsets are not gated.
- R12: In supervisor mode the supervisor register bit is not consulted. Without virtualization, the hypervisor register bit is not consulted either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_i | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| virt_i | input | 1 | Virtualization mode active |
| fp_present_i | input | 1 | Separate floating-point register file present |
| dec_fp_i | input | 1 | Decoded instruction is floating-point |
| dec_tjump_i | input | 1 | Decoded instruction is a table jump (either form) |
| dec_vtcsr_i | input | 1 | Decoded instruction accesses the jump vector table CSR |
| m_wr_i | input | 1 | Write strobe, machine register |
| m_wdata_i | input | XLEN | Write data, machine register |
| h_wr_i | input | 1 | Write strobe, hypervisor register |
| h_wdata_i | input | XLEN | Write data, hypervisor register |
| s_wr_i | input | 1 | Write strobe, supervisor register |
| s_wdata_i | input | XLEN | Write data, supervisor register |
| m_rdata_o | output | XLEN | Machine register read value |
| h_rdata_o | output | XLEN | Hypervisor register read value |
| s_rdata_o | output | XLEN | Supervisor register read value |
| trap_o | output | 1 | Trap request for the current instruction |
| trap_virt_o | output | 1 | Trap type: 1 virtual instruction, 0 illegal instruction |

## Verification
The bench targets trap precedence when several levels block the same access. A machine-level block must stay ILLEGAL even when virtualized; a design that checked the hypervisor bit first would wrongly report VIRTUAL. It sets `fp_present_i` and then clears it, to confirm that a write made during the lock never lands; a design that merely masked the read would reveal the stale bit afterwards. It also clears a machine bit while lower bits stay stored, to confirm that the lower reads drop to zero and recover. A design that gated floating-point operations without regard to `fp_present_i`, or that let a table-jump access pass on bit 1 alone, fails the directed trap checks.

// File: rtl/fen_pkg.sv
package fen_pkg;
    // index of each enable inside the packed two-bit field
    localparam int unsigned EN_FP = 0;
    localparam int unsigned EN_TJ = 1;
    localparam int unsigned EN_W  = 2;
    // bit positions inside the architectural register value
    localparam int unsigned POS_FP = 1;
    localparam int unsigned POS_TJ = 2;

    typedef logic [EN_W-1:0] en_t;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        V_PASS    = 2'd0,
        V_ILLEGAL = 2'd1,
        V_VIRTUAL = 2'd2
    } verdict_e;
endpackage

// File: rtl/fen_level.sv
module fen_level
    import fen_pkg::*;
#(
    parameter int unsigned XLEN    = 64,
    parameter bit          LOCK_FP = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [XLEN-1:0] wdata,
    input  logic            fp_lock,
    input  en_t             upper,
    output en_t             eff,
    output logic [XLEN-1:0] rdata
);
    en_t  store_q;
    en_t  lock_mask;
    logic fp_frozen;
    logic [XLEN-1:0] unused_wdata;

    assign unused_wdata = wdata;

    generate
        if (LOCK_FP) begin : g_lock
            assign lock_mask = {1'b1, ~fp_lock};
            assign fp_frozen = fp_lock;
        end else begin : g_free
            assign lock_mask = '1;
            assign fp_frozen = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (wr) begin
            store_q[EN_TJ] <= wdata[POS_TJ];
            if (!fp_frozen) begin
                store_q[EN_FP] <= wdata[POS_FP];
            end
        end
    end

    assign eff = store_q & upper & lock_mask;

    always_comb begin
        rdata         = '0;
        rdata[POS_FP] = eff[EN_FP];
        rdata[POS_TJ] = eff[EN_TJ];
    end

    generate
        if (LOCK_FP) begin : g_lock_chk
            // R3: a write made while locked never reaches the stored bit
            a_r3_fp_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
                $past(fp_lock) |-> $stable(store_q[EN_FP]));
        end
    endgenerate
endmodule

// File: rtl/fen_check.sv
module fen_check
    import fen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic [1:0] priv,
    input  logic virt,
    input  logic fp_present,
    input  logic dec_fp,
    input  logic dec_tjump,
    input  logic dec_vtcsr,
    input  en_t  m_eff,
    input  en_t  h_eff,
    input  en_t  s_eff,
    output logic trap,
    output logic trap_virt
);
    en_t      need;
    logic     blk_m, blk_h, blk_s;
    verdict_e verdict;

    always_comb begin
        need        = '0;
        need[EN_FP] = dec_fp & ~fp_present;
        need[EN_TJ] = dec_tjump | dec_vtcsr;
    end

    assign blk_m = |(need & ~m_eff);
    assign blk_h = |(need & ~h_eff);
    assign blk_s = |(need & ~s_eff);

    always_comb begin
        verdict = V_PASS;
        unique case (priv_e'(priv))
            PRIV_M: verdict = V_PASS;
            PRIV_S: begin
                if (blk_m)              verdict = V_ILLEGAL;
                else if (virt && blk_h) verdict = V_VIRTUAL;
            end
            PRIV_U: begin
                if (blk_m)              verdict = V_ILLEGAL;
                else if (virt && blk_h) verdict = V_VIRTUAL;
                else if (blk_s)         verdict = virt ? V_VIRTUAL : V_ILLEGAL;
            end
            default: verdict = V_PASS;
        endcase
    end

    always_comb begin
        trap      = 1'b0;
        trap_virt = 1'b0;
        unique case (verdict)
            V_ILLEGAL: trap = 1'b1;
            V_VIRTUAL: begin
                trap      = 1'b1;
                trap_virt = 1'b1;
            end
            default: ;
        endcase
    end

    // R5: machine mode is never trapped
    a_r5_machine_free: assert property (@(posedge clk) disable iff (!rst_n)
        (priv == 2'b11) |-> !trap);
    // R11: no decode flag means no trap
    a_r11_flag_needed: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (dec_fp || dec_tjump || dec_vtcsr));
    // R7: a virtual trap only arises while virtualized
    a_r7_virtual_needs_v: assert property (@(posedge clk) disable iff (!rst_n)
        trap_virt |-> (virt && trap));
    // R9: floating-point alone is never trapped with a separate register file
    a_r9_fp_present_free: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_present && !dec_tjump && !dec_vtcsr) |-> !trap);
    // R6: a machine-level block is always an illegal trap
    a_r6_machine_block: assert property (@(posedge clk) disable iff (!rst_n)
        (priv != 2'b11 && blk_m) |-> (trap && !trap_virt));
endmodule

// File: rtl/fen_access_gate.sv
module fen_access_gate
    import fen_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      priv_i,
    input  logic            virt_i,
    input  logic            fp_present_i,
    input  logic            dec_fp_i,
    input  logic            dec_tjump_i,
    input  logic            dec_vtcsr_i,
    input  logic            m_wr_i,
    input  logic [XLEN-1:0] m_wdata_i,
    input  logic            h_wr_i,
    input  logic [XLEN-1:0] h_wdata_i,
    input  logic            s_wr_i,
    input  logic [XLEN-1:0] s_wdata_i,
    output logic [XLEN-1:0] m_rdata_o,
    output logic [XLEN-1:0] h_rdata_o,
    output logic [XLEN-1:0] s_rdata_o,
    output logic            trap_o,
    output logic            trap_virt_o
);
    en_t m_eff, h_eff, s_eff;

    fen_level #(.XLEN(XLEN), .LOCK_FP(1'b1)) u_m (
        .clk(clk), .rst_n(rst_n), .wr(m_wr_i), .wdata(m_wdata_i),
        .fp_lock(fp_present_i), .upper('1), .eff(m_eff), .rdata(m_rdata_o));

    fen_level #(.XLEN(XLEN), .LOCK_FP(1'b0)) u_h (
        .clk(clk), .rst_n(rst_n), .wr(h_wr_i), .wdata(h_wdata_i),
        .fp_lock(fp_present_i), .upper(m_eff), .eff(h_eff), .rdata(h_rdata_o));

    fen_level #(.XLEN(XLEN), .LOCK_FP(1'b0)) u_s (
        .clk(clk), .rst_n(rst_n), .wr(s_wr_i), .wdata(s_wdata_i),
        .fp_lock(fp_present_i), .upper(h_eff), .eff(s_eff), .rdata(s_rdata_o));

    fen_check u_chk (
        .clk(clk), .rst_n(rst_n), .priv(priv_i), .virt(virt_i),
        .fp_present(fp_present_i), .dec_fp(dec_fp_i), .dec_tjump(dec_tjump_i),
        .dec_vtcsr(dec_vtcsr_i), .m_eff(m_eff), .h_eff(h_eff), .s_eff(s_eff),
        .trap(trap_o), .trap_virt(trap_virt_o));

    // R4: a lower register never shows a bit the level above has cleared
    a_r4_h_within_m: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rdata_o & ~m_rdata_o) == '0);
    a_r4_s_within_h: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rdata_o & ~h_rdata_o) == '0);
    // R3: bit 1 reads zero everywhere while the floating-point file is present
    a_r3_fp_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fp_present_i |-> !(m_rdata_o[1] || h_rdata_o[1] || s_rdata_o[1]));
endmodule

// File: tb/test_fen_access_gate.sv
module test_fen_access_gate;
    localparam int XLEN = 64;
    localparam logic [1:0] PU = 2'b00, PS = 2'b01, PM = 2'b11;
    localparam logic [1:0] NONE = 2'b00, ILL = 2'b10, VIRT = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] priv = PU;
    logic virt = 1'b0, fp_present = 1'b0;
    logic dec_fp = 1'b0, dec_tj = 1'b0, dec_vt = 1'b0;
    logic m_wr = 1'b0, h_wr = 1'b0, s_wr = 1'b0;
    logic [XLEN-1:0] m_wd = '0, h_wd = '0, s_wd = '0;
    logic [XLEN-1:0] m_rd, h_rd, s_rd;
    logic trap, trap_virt;
    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fen_access_gate #(.XLEN(XLEN)) i_fen_access_gate (
        .clk(clk), .rst_n(rst_n), .priv_i(priv), .virt_i(virt),
        .fp_present_i(fp_present), .dec_fp_i(dec_fp), .dec_tjump_i(dec_tj),
        .dec_vtcsr_i(dec_vt), .m_wr_i(m_wr), .m_wdata_i(m_wd),
        .h_wr_i(h_wr), .h_wdata_i(h_wd), .s_wr_i(s_wr), .s_wdata_i(s_wd),
        .m_rdata_o(m_rd), .h_rdata_o(h_rd), .s_rdata_o(s_rd),
        .trap_o(trap), .trap_virt_o(trap_virt));

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_all(input logic [XLEN-1:0] m, input logic [XLEN-1:0] h, input logic [XLEN-1:0] s);
        @(negedge clk);
        m_wr = 1'b1; h_wr = 1'b1; s_wr = 1'b1;
        m_wd = m; h_wd = h; s_wd = s;
        @(negedge clk);
        m_wr = 1'b0; h_wr = 1'b0; s_wr = 1'b0;
    endtask

    task automatic wr_m(input logic [XLEN-1:0] m);
        @(negedge clk);
        m_wr = 1'b1; m_wd = m;
        @(negedge clk);
        m_wr = 1'b0;
    endtask

    // flags: {fp, tj, vt}
    task automatic gate(input string req, input logic [1:0] p, input logic v,
                        input logic [2:0] flags, input logic [1:0] exp);
        priv = p; virt = v;
        {dec_fp, dec_tj, dec_vt} = flags;
        #2;
        chk(req, {62'd0, trap, trap_virt}, {62'd0, exp});
        {dec_fp, dec_tj, dec_vt} = 3'b000;
        #1;
    endtask

    task automatic t_reset;
        chk("R1 m", m_rd, '0); chk("R1 h", h_rd, '0); chk("R1 s", s_rd, '0);
        gate("R1 gated", PU, 1'b0, 3'b010, ILL);
    endtask

    task automatic t_layout;
        fp_present = 1'b0;
        wr_all('1, '1, '1);
        chk("R2 m", m_rd, 64'h6); chk("R2 s", s_rd, 64'h6);
        wr_m(64'h4);
        chk("R2 m bit2 only", m_rd, 64'h4);
        wr_all('0, '0, '0);
    endtask

    task automatic t_fp_lock;
        fp_present = 1'b1;
        wr_all('1, '1, '1);
        chk("R3 m", m_rd, 64'h4); chk("R3 h", h_rd, 64'h4); chk("R3 s", s_rd, 64'h4);
        fp_present = 1'b0;
        #1;
        chk("R3 write ignored", m_rd, 64'h4);
        wr_m(64'h6);
        chk("R3 unlocked", m_rd, 64'h6);
    endtask

    task automatic t_hier;
        wr_all(64'h6, 64'h6, 64'h6);
        wr_m(64'h4);
        chk("R4 h", h_rd, 64'h4); chk("R4 s", s_rd, 64'h4);
        wr_m(64'h6);
        chk("R4 h back", h_rd, 64'h6); chk("R4 s back", s_rd, 64'h6);
        wr_all(64'h6, 64'h2, 64'h6);
        chk("R4 s via h", s_rd, 64'h2);
    endtask

    task automatic t_machine;
        wr_all('0, '0, '0);
        gate("R5 M all flags", PM, 1'b0, 3'b111, NONE);
        gate("R5 M virt", PM, 1'b1, 3'b010, NONE);
    endtask

    task automatic t_illegal;
        wr_all('0, '1, '1);
        gate("R6 S", PS, 1'b0, 3'b010, ILL);
        gate("R6 S virt", PS, 1'b1, 3'b010, ILL);
        gate("R6 U virt", PU, 1'b1, 3'b001, ILL);
    endtask

    task automatic t_virtual;
        wr_all(64'h6, '0, '1);
        gate("R7 S virt", PS, 1'b1, 3'b010, VIRT);
        gate("R12 S no virt", PS, 1'b0, 3'b010, NONE);
    endtask

    task automatic t_user;
        wr_all(64'h6, 64'h6, '0);
        gate("R8 U", PU, 1'b0, 3'b010, ILL);
        gate("R8 U virt", PU, 1'b1, 3'b010, VIRT);
        gate("R12 S ignores s", PS, 1'b1, 3'b010, NONE);
    endtask

    task automatic t_fp;
        wr_all('0, '0, '0);
        fp_present = 1'b1;
        gate("R9 fp present", PU, 1'b0, 3'b100, NONE);
        fp_present = 1'b0;
        gate("R9 fp gated", PU, 1'b0, 3'b100, ILL);
        wr_all(64'h2, 64'h2, 64'h2);
        gate("R9 fp enabled", PU, 1'b1, 3'b100, NONE);
        gate("R10 tj on bit1 only", PU, 1'b0, 3'b010, ILL);
    endtask

    task automatic t_vtcsr;
        wr_all(64'h4, 64'h4, 64'h4);
        gate("R10 vt allowed", PS, 1'b0, 3'b001, NONE);
        gate("R10 tj allowed", PU, 1'b1, 3'b010, NONE);
        wr_m(64'h2);
        gate("R10 vt blocked", PS, 1'b0, 3'b001, ILL);
    endtask

    task automatic t_none;
        wr_all('0, '0, '0);
        gate("R11 U", PU, 1'b0, 3'b000, NONE);
        gate("R11 S virt", PS, 1'b1, 3'b000, NONE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset; t_layout; t_fp_lock; t_hier; t_machine; t_illegal;
        t_virtual; t_user; t_fp; t_vtcsr; t_none;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule